// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the slave-side unit that answers an SMBus alert response query. When its alert line is pending, a master that wants to know who raised the alert sends a read to the fixed alert response address. The block acknowledges that address byte and returns its own 7-bit device address with a trailing 1. If several devices answer at once, each sends its address one bit at a time onto the shared open-drain line. A device that sends a 1 but sees a 0 on the line drops out, so the lowest address wins.

When `pec_en` is set and the master acknowledges the address byte, the block follows it with a CRC-8 packet error checking byte. A responder that wins the arbitration gives a one-cycle `responded` pulse. If the out-of-limit condition has cleared and its status has been read, the same cycle also carries `alert_release`, which the surrounding logic uses to drop the alert. Otherwise the alert stays pending and the master has to query again. The block works on synchronously sampled SCL and SDA. The normal register protocol and the input glitch filtering lie outside this block.

Top module: `smb_alert_responder`

## Requirements
- R1: After a START, the block acknowledges a received byte equal to 8'h19 (address 0001100 followed by read bit 1) only when `alert_pending` is 1. The acknowledge is `sda_pull` high during the ninth clock.
- R2: The block does not acknowledge, and keeps SDA released, for any other first byte, including address 0001100 with write bit 0, or for any byte while `alert_pending` is 0.
- R3: After the acknowledge, the block sends the byte {`dev_addr`, 1'b1} most significant bit first, pulling SDA low for each 0 bit.
- R4: On any SCL rise where the block sends a 1 but samples SDA as 0, it loses arbitration and releases SDA until the next START. The master therefore reads the lower of the competing addresses.
- R5: `responded` is a single-cycle pulse, given once per transfer when the address byte has been sent in full without losing arbitration. It is never given to a loser.
- R6: `alert_release` pulses in the same cycle as `responded`, and only when `cond_gone` and `stat_read` are both 1 at that time.
- R7: When `pec_en` is 1 and the master acknowledges the address byte, the block sends one more byte. That byte is the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, data MSB first) over 8'h19 followed by the address byte.
- R8: When `pec_en` is 0, the block releases SDA after the address byte, so a further read by the master returns 8'hFF.
- R9: A START or repeated START restarts address reception from any state. A STOP returns the block to idle with SDA released.
- R10: `sda_pull` changes only while SCL is low.
- R11: Out of reset, `sda_pull`, `responded` and `alert_release` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| dev_addr | input | 7 | Own 7-bit device address |
| alert_pending | input | 1 | Alert output is currently asserted |
| pec_en | input | 1 | Append the PEC byte |
| cond_gone | input | 1 | Out-of-limit condition no longer present |
| stat_read | input | 1 | Related status register has been read |
| sda_pull | output | 1 | Drive SDA low when 1 |
| responded | output | 1 | One-cycle pulse on a won response |
| alert_release | output | 1 | One-cycle pulse permitting the alert to drop |

## Verification
Line changes reach the state machine through two sampling registers, so `sda_pull` moves two to three clocks after an SCL fall. The master model waits eight clocks after each SCL transition and reads SDA in the middle of the high phase, which keeps it clear of that delay. `responded` and `alert_release` follow the eighth data rise by the same two to three clocks and always come before the master's next SCL fall. The bench counts these pulses over the whole transfer and compares the counts at the STOP. The sweep covers every legal device address, including mixed settings of PEC and release inputs, and a grid of competing address pairs.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter logic [6:0] ARA = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] dev_addr,
  input  logic       alert_pending,
  input  logic       pec_en,
  input  logic       cond_gone,
  input  logic       stat_read,
  output logic       sda_pull,
  output logic       responded,
  output logic       alert_release
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_TX, S_MACK, S_DONE} st_t;

  localparam logic [7:0] ARA_RD = {ARA, 1'b1};

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  st_t        st;
  logic       scl_r, scl_p, sda_r, sda_p;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       in_pec, ack_seen, go_pec;

  wire rise      = scl_r & ~scl_p;
  wire fall      = ~scl_r & scl_p;
  wire start_det = scl_r & scl_p & sda_p & ~sda_r;
  wire stop_det  = scl_r & scl_p & ~sda_p & sda_r;
  wire [7:0] tx_byte = {dev_addr, 1'b1};
  wire [7:0] pec     = crc8(crc8(8'h00, ARA_RD), tx_byte);
  wire [7:0] rx_next = {sh[6:0], sda_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_r, scl_p, sda_r, sda_p} <= 4'hF;
    end else begin
      scl_r <= scl_in;
      scl_p <= scl_r;
      sda_r <= sda_in;
      sda_p <= sda_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sh <= '0;
      cnt <= '0;
      in_pec <= 1'b0;
      ack_seen <= 1'b0;
      go_pec <= 1'b0;
      sda_pull <= 1'b0;
      responded <= 1'b0;
      alert_release <= 1'b0;
    end else begin
      responded <= 1'b0;
      alert_release <= 1'b0;
      if (start_det) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: if (rise) begin
            sh  <= rx_next;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7)
              st <= (rx_next == ARA_RD && alert_pending) ? S_ACK : S_DONE;
          end
          S_ACK: if (fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              st <= S_TX;
              sh <= tx_byte;
              cnt <= '0;
              in_pec <= 1'b0;
              sda_pull <= ~dev_addr[6];
            end
          end
          S_TX: begin
            if (rise) begin
              if (sh[7] && !sda_r) begin
                st <= S_DONE;
                sda_pull <= 1'b0;
              end else begin
                cnt <= cnt + 4'd1;
                if (cnt == 4'd7) begin
                  st <= S_MACK;
                  ack_seen <= 1'b0;
                  if (!in_pec) begin
                    responded <= 1'b1;
                    alert_release <= cond_gone & stat_read;
                  end
                end
              end
            end else if (fall) begin
              sh <= {sh[6:0], 1'b1};
              sda_pull <= ~sh[6];
            end
          end
          S_MACK: begin
            if (rise) begin
              ack_seen <= 1'b1;
              go_pec <= ~sda_r & pec_en & ~in_pec;
              if (sda_r || !pec_en || in_pec) st <= S_DONE;
            end else if (fall) begin
              if (!ack_seen) sda_pull <= 1'b0;
              else if (go_pec) begin
                st <= S_TX;
                sh <= pec;
                cnt <= '0;
                in_pec <= 1'b1;
                sda_pull <= ~pec[7];
              end
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic responded,
  input logic alert_release,
  input logic stop_det
);
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in);
  a_r6_release_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    alert_release |-> responded);
  a_r5_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    responded |=> !responded);
  a_r9_stop_frees_sda: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
  a_r5_resp_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    responded |-> scl_in);
endmodule

bind smb_alert_responder smb_alert_responder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .responded(responded), .alert_release(alert_release), .stop_det(stop_det)
);

// File: tb/test_smb_alert_responder.sv
module test_smb_alert_responder;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, rival_pull = 1'b0;
  logic [6:0] dev_addr = 7'h10;
  logic alert_pending = 1'b1, pec_en = 1'b0, cond_gone = 1'b0, stat_read = 1'b0;
  logic sda_pull, responded, alert_release, sda_bus;
  int total = 0, bad = 0, n_resp = 0, n_rel = 0;
  logic rival_on = 1'b0, rival_lost = 1'b0;
  logic [6:0] rival_addr = 7'h00;

  assign sda_bus = ~(sda_pull | rival_pull | m_low);

  always #(CLK_P/2) clk = ~clk;

  smb_alert_responder i_smb_alert_responder (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .dev_addr(dev_addr), .alert_pending(alert_pending), .pec_en(pec_en),
    .cond_gone(cond_gone), .stat_read(stat_read), .sda_pull(sda_pull),
    .responded(responded), .alert_release(alert_release)
  );

  always @(posedge clk) begin
    if (responded) n_resp++;
    if (alert_release) n_rel++;
  end

  function automatic logic [7:0] crc_ref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] m;
    logic [7:0] c;
    m = {a, b};
    c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ m[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic m_start();
    m_low = 1'b0; half(); scl = 1'b1; half(); m_low = 1'b1; half(); scl = 1'b0; half();
  endtask

  task automatic m_stop();
    m_low = 1'b1; half(); scl = 1'b1; half(); m_low = 1'b0; half();
  endtask

  task automatic wbit(input logic b);
    m_low = ~b; half(); scl = 1'b1; half(); scl = 1'b0;
  endtask

  task automatic rbit(output logic v);
    m_low = 1'b0; half(); scl = 1'b1;
    repeat (HALF/2) @(negedge clk);
    v = sda_bus;
    repeat (HALF/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(ack);
  endtask

  task automatic rbyte(input logic use_rival, output logic [7:0] b);
    logic [7:0] rb;
    rb = {rival_addr, 1'b1};
    rival_lost = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic v;
      rival_pull = use_rival & rival_on & ~rival_lost & ~rb[i];
      rbit(v);
      if (rb[i] && !v) rival_lost = 1'b1;
      b[i] = v;
    end
    rival_pull = 1'b0;
  endtask

  // Full query: ARA read, address byte, optional master ACK and second byte.
  task automatic query(input logic macq, input logic use_rival,
                       output logic ack, output logic [7:0] b1, output logic [7:0] b2);
    m_start();
    wbyte(8'h19, ack);
    b2 = 8'hFF;
    rbyte(use_rival, b1);
    wbit(~macq);
    if (macq) begin
      rbyte(1'b0, b2);
      wbit(1'b1);
    end
    m_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b1, b2;
    int r0, l0;
    repeat (3) @(negedge clk);
    chk(sda_pull === 1'b0 && responded === 1'b0 && alert_release === 1'b0, "R11",
        {sda_pull, responded, alert_release}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep every legal address, mixing PEC and release inputs.
    for (int a = 0; a < 128; a++) begin
      if (a == 12) continue;
      dev_addr = a[6:0];
      pec_en = a[0]; cond_gone = a[1]; stat_read = a[2];
      r0 = n_resp; l0 = n_rel;
      query(1'b1, 1'b0, ack, b1, b2);
      chk(ack === 1'b0, "R1 ack", ack, 0);
      chk(b1 === {a[6:0], 1'b1}, "R3 addr byte", b1, {a[6:0], 1'b1});
      if (pec_en)
        chk(b2 === crc_ref(8'h19, {a[6:0], 1'b1}), "R7 pec", b2, crc_ref(8'h19, {a[6:0], 1'b1}));
      else
        chk(b2 === 8'hFF, "R8 no pec", b2, 8'hFF);
      chk(n_resp - r0 == 1, "R5 responded", n_resp - r0, 1);
      chk(n_rel - l0 == int'(a[1] & a[2]), "R6 release", n_rel - l0, int'(a[1] & a[2]));
    end

    // Arbitration against a competing responder.
    pec_en = 1'b0; cond_gone = 1'b1; stat_read = 1'b1; rival_on = 1'b1;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [6:0] da, ra, lo;
        da = 7'(i * 21 + 3);
        ra = 7'(j * 19 + 5);
        if (da == ra || da == 7'h0C || ra == 7'h0C) continue;
        dev_addr = da; rival_addr = ra;
        lo = (da < ra) ? da : ra;
        r0 = n_resp; l0 = n_rel;
        query(1'b0, 1'b1, ack, b1, b2);
        chk(b1 === {lo, 1'b1}, "R4 winner byte", b1, {lo, 1'b1});
        chk(n_resp - r0 == int'(da < ra), "R4 R5 win pulse", n_resp - r0, int'(da < ra));
        chk(n_rel - l0 == int'(da < ra), "R6 no release on loss", n_rel - l0, int'(da < ra));
      end
    end
    rival_on = 1'b0;

    // No alert pending: no acknowledge, no drive.
    dev_addr = 7'h22; alert_pending = 1'b0;
    r0 = n_resp;
    query(1'b0, 1'b0, ack, b1, b2);
    chk(ack === 1'b1, "R2 no ack idle alert", ack, 1);
    chk(b1 === 8'hFF, "R2 sda released", b1, 8'hFF);
    chk(n_resp == r0, "R2 no pulse", n_resp - r0, 0);
    alert_pending = 1'b1;

    // Wrong addresses.
    m_start(); wbyte(8'h18, ack); m_stop();
    chk(ack === 1'b1, "R2 write bit", ack, 1);
    m_start(); wbyte(8'h1B, ack); m_stop();
    chk(ack === 1'b1, "R2 other addr", ack, 1);

    // Repeated START in the middle of the address byte.
    r0 = n_resp;
    m_start();
    for (int i = 0; i < 5; i++) wbit(i[0]);
    m_start();
    wbyte(8'h19, ack);
    rbyte(1'b0, b1);
    wbit(1'b1);
    m_stop();
    chk(ack === 1'b0, "R9 restart ack", ack, 0);
    chk(b1 === {7'h22, 1'b1}, "R9 restart byte", b1, {7'h22, 1'b1});
    chk(n_resp - r0 == 1, "R9 restart pulse", n_resp - r0, 1);
    chk(sda_pull === 1'b0, "R9 idle after stop", sda_pull, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule